// File: doc/BRIEF.md
# ECC Error Capture Log

This block sits beside a memory controller's ECC logic and records what that logic reports about failing reads. Each report is a one-cycle event. It says whether the error was correctable or uncorrectable and gives the failing 4 KiB block address, an 8-bit syndrome and a channel bit. The block sets a sticky flag for the kind of error it saw. It also keeps one logged record: the block address, the syndrome and the channel.

An uncorrectable error may displace a record that a correctable error left behind. A correctable error never displaces anything that is already logged. Software reads the registers through a single-cycle port and clears the flags by writing ones to them. A command register enables each flag onto a level error output.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `err_out` is low.
- R2: A correctable event sets status bit 0 and an uncorrectable event sets status bit 7 on the next clock edge. Both flags stay set until software clears them.
- R3: Writing the status register (word 0) clears each flag whose data bit is 1. A 0 leaves that flag alone, and the value 0x0081 clears both flags.
- R4: The address register (word 1) returns the logged block number in bits 31:12 and zero in bits 11:0.
- R5: The syndrome register (word 2) returns the logged syndrome in bits 7:0. The channel register (word 3) returns the logged channel in bit 0. All other bits of both registers read zero.
- R6: When no uncorrectable flag is set, an uncorrectable event replaces the block, syndrome and channel with its own values, even if a correctable error is logged.
- R7: A correctable event logs its block, syndrome and channel only when both flags are clear. Otherwise the record is left unchanged.
- R8: An uncorrectable event that arrives while the uncorrectable flag is set leaves the record unchanged.
- R9: When an event arrives in the same cycle as a write that clears its flag, the flag ends up set. The decision whether to log uses the flag values held before that cycle.
- R10: `err_out` is high exactly when (status bit 0 AND command bit 7) OR (status bit 7 AND command bit 8).
- R11: Reserved bits of the status and command registers read zero and ignore writes. Writes to words 1 to 3 have no effect, and words 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle error event strobe |
| ev_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_blk | input | ADDR_W-BLK_LSB | Failing block number (address bits 31:12) |
| ev_syn | input | SYN_W | ECC syndrome |
| ev_chan | input | 1 | Channel of the failing access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | ADDR_W | Combinational read data of the addressed word |
| err_out | output | 1 | Level error signal |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 12-bit block offset, an 8-bit syndrome and eight register words. It sweeps every combination of four things.
- The flags already set: none, correctable, uncorrectable, or both.
- The incoming event: none, correctable, or uncorrectable.
- Which flags are cleared in that same cycle.
- The two enable bits.

That reaches every overwrite and set-versus-clear ordering. Each case uses distinct block, syndrome and channel values, so a record that was wrongly kept or wrongly replaced shows up.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  parameter int RA_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_valid,
  input  logic                      ev_ue,
  input  logic [ADDR_W-BLK_LSB-1:0] ev_blk,
  input  logic [SYN_W-1:0]          ev_syn,
  input  logic                      ev_chan,
  input  logic                      reg_we,
  input  logic [RA_W-1:0]           reg_addr,
  input  logic [15:0]               reg_wdata,
  output logic [ADDR_W-1:0]         reg_rdata,
  output logic                      err_out
);
  localparam int BLK_W  = ADDR_W - BLK_LSB;
  localparam int CE_BIT = 0;
  localparam int UE_BIT = 7;
  localparam int CE_EN  = 7;
  localparam int UE_EN  = 8;
  localparam logic [RA_W-1:0] W_STS = RA_W'(0);
  localparam logic [RA_W-1:0] W_ADR = RA_W'(1);
  localparam logic [RA_W-1:0] W_SYN = RA_W'(2);
  localparam logic [RA_W-1:0] W_CHN = RA_W'(3);
  localparam logic [RA_W-1:0] W_CMD = RA_W'(4);

  logic             ce_q, ue_q, en_ce_q, en_ue_q, chan_q;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;

  wire wr_sts = reg_we && (reg_addr == W_STS);
  wire wr_cmd = reg_we && (reg_addr == W_CMD);
  wire clr_ce = wr_sts && reg_wdata[CE_BIT];
  wire clr_ue = wr_sts && reg_wdata[UE_BIT];
  wire ce_ev  = ev_valid && !ev_ue;
  wire ue_ev  = ev_valid && ev_ue;
  wire take   = (ue_ev && !ue_q) || (ce_ev && !ce_q && !ue_q);

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[15:9], reg_wdata[6:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
      en_ce_q <= 1'b0;
      en_ue_q <= 1'b0;
      blk_q   <= '0;
      syn_q   <= '0;
      chan_q  <= 1'b0;
    end else begin
      ce_q <= ce_ev || (ce_q && !clr_ce);
      ue_q <= ue_ev || (ue_q && !clr_ue);
      if (wr_cmd) begin
        en_ce_q <= reg_wdata[CE_EN];
        en_ue_q <= reg_wdata[UE_EN];
      end
      if (take) begin
        blk_q  <= ev_blk;
        syn_q  <= ev_syn;
        chan_q <= ev_chan;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      W_STS: begin
        reg_rdata[CE_BIT] = ce_q;
        reg_rdata[UE_BIT] = ue_q;
      end
      W_ADR:   reg_rdata[ADDR_W-1:BLK_LSB] = blk_q;
      W_SYN:   reg_rdata[SYN_W-1:0] = syn_q;
      W_CHN:   reg_rdata[0] = chan_q;
      W_CMD: begin
        reg_rdata[CE_EN] = en_ce_q;
        reg_rdata[UE_EN] = en_ue_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign err_out = (ce_q && en_ce_q) || (ue_q && en_ue_q);

  p_ce_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_ev |=> ce_q);
  p_ue_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ue_ev |=> ue_q);
  p_ue_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_q && !(reg_we && reg_addr == W_STS && reg_wdata[UE_BIT])) |=> ue_q);
  p_ue_logs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_ev && !ue_q) |=> (blk_q == $past(ev_blk) && syn_q == $past(ev_syn)));
  p_ce_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ev && (ce_q || ue_q)) |=> ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));
  p_ue_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_ev && ue_q) |=> ($stable(blk_q) && $stable(syn_q) && $stable(chan_q)));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ev && clr_ce) |=> ce_q);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ce_q && !en_ue_q) |-> !err_out);
endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0, ev_ue = 1'b0, ev_chan = 1'b0;
  logic [19:0] ev_blk = '0;
  logic [7:0]  ev_syn = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_out;

  int n_run = 0, n_fail = 0;
  logic        m_ce = 0, m_ue = 0, m_ch = 0, m_ece = 0, m_eue = 0;
  logic [19:0] m_blk = '0;
  logic [7:0]  m_syn = '0;

  always #2.5 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ue(ev_ue),
    .ev_blk(ev_blk), .ev_syn(ev_syn), .ev_chan(ev_chan),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_out(err_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input logic ev, input logic ue, input logic [19:0] blk,
                      input logic [7:0] syn, input logic ch, input logic we,
                      input logic [2:0] wa, input logic [15:0] wd);
    logic tk;
    @(negedge clk);
    ev_valid = ev; ev_ue = ue; ev_blk = blk; ev_syn = syn; ev_chan = ch;
    reg_we = we; reg_addr = wa; reg_wdata = wd;
    tk = ev && (ue ? !m_ue : (!m_ce && !m_ue));
    if (tk) begin m_blk = blk; m_syn = syn; m_ch = ch; end
    m_ce = (ev && !ue) || (m_ce && !(we && wa == 3'd0 && wd[0]));
    m_ue = (ev && ue)  || (m_ue && !(we && wa == 3'd0 && wd[7]));
    if (we && wa == 3'd4) begin m_ece = wd[7]; m_eue = wd[8]; end
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic check_all(input string st_tag, input string log_tag);
    logic [31:0] d;
    rd(3'd0, d); chk(st_tag, d, {24'd0, m_ue, 6'd0, m_ce});
    rd(3'd1, d); chk(log_tag, d, {m_blk, 12'd0});
    rd(3'd2, d); chk(log_tag, d, {24'd0, m_syn});
    rd(3'd3, d); chk(log_tag, d, {31'd0, m_ch});
    chk("R10", {31'd0, err_out}, {31'd0, (m_ce && m_ece) || (m_ue && m_eue)});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1", d, 32'd0);
    end
    chk("R1", {31'd0, err_out}, 32'd0);

    // R2 stickiness across idle cycles
    step(1, 0, 20'hABCDE, 8'h5A, 1, 0, 0, 0);
    step(1, 1, 20'h12345, 8'hC3, 0, 0, 0, 0);
    repeat (5) step(0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R2", "R6");

    // R11 reserved bits and read-only words
    step(0, 0, 0, 0, 0, 1, 3'd4, 16'hFFFF);
    rd(3'd4, d); chk("R11", d, 32'h0000_0180);
    step(0, 0, 0, 0, 0, 1, 3'd0, 16'hFF7E);
    step(0, 0, 0, 0, 0, 1, 3'd1, 16'hFFFF);
    step(0, 0, 0, 0, 0, 1, 3'd2, 16'hFFFF);
    step(0, 0, 0, 0, 0, 1, 3'd3, 16'hFFFF);
    check_all("R11", "R11");
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R11", d, 32'd0);
    end

    k = 0;
    for (int pre = 0; pre < 4; pre++)
      for (int ev = 0; ev < 3; ev++)
        for (int clr = 0; clr < 4; clr++)
          for (int en = 0; en < 4; en++) begin
            k++;
            step(0, 0, 0, 0, 0, 1, 3'd0, 16'h0081);
            step(0, 0, 0, 0, 0, 1, 3'd4, 16'(((en & 1) << 7) | ((en >> 1) << 8)));
            if (pre[0]) step(1, 0, 20'(k * 2 * 40503 + 1445), 8'(k * 74 + 3), k[1], 0, 0, 0);
            if (pre[1]) step(1, 1, 20'((k * 2 + 1) * 40503 + 1445), 8'(k * 74 + 40), k[2], 0, 0, 0);
            if (pre == 0 && ev == 0) check_all("R3", "R1");
            step(ev != 0, ev == 2, 20'(k * 3 * 40503 + 7), 8'(k * 13 + 99), k[0] ^ k[3],
                 clr != 0, 3'd0, 16'((clr & 1) | ((clr >> 1) << 7)));
            if (ev != 0 && clr != 0)       check_all("R9", ev == 2 ? "R8" : "R7");
            else if (ev == 2 && pre[1])    check_all("R3", "R8");
            else if (ev == 2)              check_all("R3", "R6");
            else if (ev == 1 && pre != 0)  check_all("R3", "R7");
            else                           check_all("R3", "R4");
          end
    // R5 distinct channel/syndrome after full clear
    step(0, 0, 0, 0, 0, 1, 3'd0, 16'h0081);
    step(1, 0, 20'hFFFFF, 8'hFF, 1, 0, 0, 0);
    check_all("R2", "R5");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule